// File: doc/BRIEF.md
# Partitioned RAM/ROM Memory Subsystem with Address Decode

This block is the memory behind an 8-bit processor that has a 16-bit address bus. It holds four 128-byte RAM banks and one 512-byte read-only bank. A decoder turns the low ten address bits into chip selects that follow a fixed map:

| Bank | Address range |
|------|---------------|
| RAM bank 0 | 0x0000–0x007F |
| RAM bank 1 | 0x0080–0x00FF |
| RAM bank 2 | 0x0100–0x017F |
| RAM bank 3 | 0x0180–0x01FF |
| ROM | 0x0200–0x03FF |

Any address with one of the six upper lines set selects nothing.

The processor side has an address, separate read and write strobes, write data, read data, and a flag that shows when the read data is driven. Reads are combinational. Writes to RAM land on the rising clock edge. The read-only bank has no read or write control of its own. It has two select inputs of opposite polarity, and it drives its byte only when the active-high select is 1 and the active-low select is 0. Its contents are computed from a parameter, not loaded.

Top module: `mem_subsys`

## Requirements
- R1: With address bits [15:10] zero and bit 9 zero, address bits [8:7] select RAM bank 0..3. Address bits [6:0] index a byte within that bank.
- R2: When wr_i is 1, rst_ni is 1 and a RAM bank is selected, wdata_i is stored at the rising clock edge. A later read of that address returns it.
- R3: When rd_i is 1 and the address selects a bank, rvalid_o is 1 and rdata_o carries the addressed byte in the same cycle, with no clock edge in between.
- R4: With address bits [15:10] zero and bit 9 one, the ROM is selected and indexed by address bits [8:0]. The byte read is addr[7:0] XOR ROM_SEED XOR {8{addr[8]}}, where ROM_SEED defaults to 8'h3C.
- R5: The ROM drives data only when its active-high select (read strobe AND address bit 9) is 1 and its active-low select (OR of address bits [15:10]) is 0. Otherwise its output is released.
- R6: A write to 0x0200–0x03FF changes no RAM byte, and the ROM still reads its computed value afterwards.
- R7: If any of address bits [15:10] is 1, no bank is selected. rvalid_o stays 0, and a write there leaves every RAM byte unchanged.
- R8: When rd_i is 0, rvalid_o is 0 and rdata_o is high impedance, whatever the address is.
- R9: At most one of the five bank selects is active in any cycle.
- R10: While rst_ni is low, writes are blocked and rvalid_o is 0 unless a read is requested.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; RAM writes on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset; blocks writes while low |
| addr_i | input | 16 | Processor address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data; high impedance when not driven |
| rvalid_o | output | 1 | 1 when rdata_o is driven by a bank |

## Verification
The bench first writes a distinct pattern to all 512 RAM addresses. It then tries to overwrite them through the ROM window and through aliases with the upper address lines set. Reading everything back separates a correct bank and index decode from banks that alias into each other, and a RAM that is never written from one that is written twice.

All 512 ROM addresses are read in turn, including both halves selected by bit 8. This separates the full 9-bit index from a truncated one. Reads with the upper lines set, and address sweeps with the read strobe low, check that nothing is driven when nothing should be.

// File: rtl/memmap_pkg.sv
package memmap_pkg;
  localparam int ADDR_W    = 16;
  localparam int DATA_W    = 8;
  localparam int RAM_AW    = 7;
  localparam int BANK_SW   = 2;
  localparam int NUM_BANKS = 1 << BANK_SW;
  localparam int ROM_AW    = RAM_AW + BANK_SW;
  localparam int DEC_W     = ROM_AW + 1;

  typedef logic [DATA_W-1:0] byte_t;

  function automatic byte_t rom_value(input logic [ROM_AW-1:0] idx, input byte_t seed);
    return idx[DATA_W-1:0] ^ seed ^ {DATA_W{idx[ROM_AW-1]}};
  endfunction
endpackage

// File: rtl/mem_addr_decode.sv
module mem_addr_decode
  import memmap_pkg::*;
#(
  parameter int AW  = ADDR_W,
  parameter int DW  = DEC_W,
  parameter int LAW = RAM_AW,
  parameter int NB  = NUM_BANKS
) (
  input  logic [AW-1:0] addr_i,
  input  logic          rd_i,
  input  logic          wr_i,
  output logic [NB-1:0] ram_cs_o,
  output logic          rom_cs_hi_o,
  output logic          rom_cs_lo_o
);
  localparam int SW = DW - 1 - LAW;

  logic          upper_clear;
  logic          rom_region;
  logic [SW-1:0] bank_idx;

  assign upper_clear = ~|addr_i[AW-1:DW];
  assign rom_region  = addr_i[DW-1];
  assign bank_idx    = addr_i[DW-2:LAW];

  for (genvar b = 0; b < NB; b++) begin : g_cs
    assign ram_cs_o[b] = (rd_i | wr_i) & upper_clear & ~rom_region
                       & (bank_idx == SW'(b));
  end

  // opposite-polarity ROM selects: high = read into ROM window, low = upper lines clear
  assign rom_cs_hi_o = rd_i & rom_region;
  assign rom_cs_lo_o = ~upper_clear;
endmodule

// File: rtl/mem_ram_bank.sv
module mem_ram_bank
  import memmap_pkg::*;
#(
  parameter int AW = RAM_AW,
  parameter int W  = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  data_o,
  output logic          drive_o
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];
  logic         we;

  assign we      = cs_i & wr_i & rst_ni;
  assign drive_o = cs_i & rd_i;
  assign data_o  = drive_o ? mem[addr_i] : '0;

  always_ff @(posedge clk_i) begin
    if (we) mem[addr_i] <= wdata_i;
  end

  p_write_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we |=> (mem[$past(addr_i)] == $past(wdata_i)));
endmodule

// File: rtl/mem_rom_bank.sv
module mem_rom_bank
  import memmap_pkg::*;
#(
  parameter int    AW   = ROM_AW,
  parameter byte_t SEED = 8'h3C
) (
  input  logic          cs_hi_i,
  input  logic          cs_lo_i,
  input  logic [AW-1:0] addr_i,
  output byte_t         data_o,
  output logic          drive_o
);
  assign drive_o = cs_hi_i & ~cs_lo_i;
  assign data_o  = drive_o ? rom_value(addr_i, SEED) : '0;
endmodule

// File: rtl/mem_subsys.sv
module mem_subsys
  import memmap_pkg::*;
#(
  parameter byte_t ROM_SEED = 8'h3C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  localparam int NSRC = NUM_BANKS + 1;

  logic [NUM_BANKS-1:0] ram_cs;
  logic                 rom_cs_hi, rom_cs_lo;
  byte_t                src_data [NSRC];
  logic [NSRC-1:0]      src_drive;
  byte_t                merged;

  mem_addr_decode u_dec (
    .addr_i      (addr_i),
    .rd_i        (rd_i),
    .wr_i        (wr_i),
    .ram_cs_o    (ram_cs),
    .rom_cs_hi_o (rom_cs_hi),
    .rom_cs_lo_o (rom_cs_lo)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_ram
    mem_ram_bank u_ram (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cs_i    (ram_cs[b]),
      .rd_i    (rd_i),
      .wr_i    (wr_i),
      .addr_i  (addr_i[RAM_AW-1:0]),
      .wdata_i (wdata_i),
      .data_o  (src_data[b]),
      .drive_o (src_drive[b])
    );
  end

  mem_rom_bank #(.SEED(ROM_SEED)) u_rom (
    .cs_hi_i (rom_cs_hi),
    .cs_lo_i (rom_cs_lo),
    .addr_i  (addr_i[ROM_AW-1:0]),
    .data_o  (src_data[NUM_BANKS]),
    .drive_o (src_drive[NUM_BANKS])
  );

  // undriven sources contribute zero, so an OR merge is enough
  always_comb begin
    merged = '0;
    for (int i = 0; i < NSRC; i++) merged |= src_data[i];
  end

  assign rvalid_o = |src_drive;
  assign rdata_o  = rvalid_o ? merged : 'z;

  p_single_select_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ram_cs, src_drive[NUM_BANKS]}));
  p_upper_blocks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|addr_i[ADDR_W-1:DEC_W]) |-> !rvalid_o);
  p_no_read_no_drive_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> !rvalid_o);
  p_rom_content_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i[ADDR_W-1:DEC_W-1] == 7'd1) |->
      (rvalid_o && rdata_o == rom_value(addr_i[ROM_AW-1:0], ROM_SEED)));
  p_ram_read_valid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i[ADDR_W-1:DEC_W-1] == 7'd0) |-> (rvalid_o && src_drive[addr_i[DEC_W-2:RAM_AW]]));
endmodule

// File: tb/sim_mem_subsys.sv
module sim_mem_subsys;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [7:0]  wdata = '0;
  wire  [7:0]  rdata;
  wire         rvalid;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [15:0] a;
    logic        v;
    logic [7:0]  d;
    string       req;
  } item_t;
  item_t q[$];

  logic [7:0] model [512];

  always #4 clk = ~clk;  // 125 MHz

  mem_subsys u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid)
  );

  function automatic logic [7:0] rom_ref(logic [8:0] i);
    return i[7:0] ^ 8'h3C ^ {8{i[8]}};
  endfunction

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37) + (a >> 8) * 8'h5B + 8'h11);
  endfunction

  task automatic wr_cyc(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1; rd = 1'b0;
    @(negedge clk);
    wr = 1'b0;
  endtask

  // driver: applies a read and pushes its expected outcome
  task automatic rd_cyc(logic [15:0] a, logic r, string req);
    item_t it;
    @(negedge clk);
    addr = a; rd = r; wr = 1'b0;
    it.a = a; it.req = req;
    it.v = r && (a[15:10] == 6'd0);
    it.d = a[9] ? rom_ref(a[8:0]) : model[a[8:0]];
    q.push_back(it);
  endtask

  // monitor: compares outputs mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        n_chk++;
        if (rvalid !== it.v || (it.v && rdata !== it.d)) begin
          n_fail++;
          $display("FAIL %s addr=%h valid=%b data=%h expected valid=%b data=%h",
                   it.req, it.a, rvalid, rdata, it.v, it.d);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R10: no read driven during reset
    repeat (3) @(negedge clk);
    n_chk++;
    if (rvalid !== 1'b0) begin
      n_fail++; $display("FAIL R10 reset valid=%b expected=0", rvalid);
    end
    @(negedge clk) rst_n = 1'b1;

    // R1 R2: fill every RAM address
    for (int a = 0; a < 512; a++) begin
      model[a] = pat(a);
      wr_cyc(16'(a), pat(a));
    end
    // R6: writes into ROM window ignored
    for (int a = 0; a < 512; a += 3) wr_cyc(16'h0200 + 16'(a), 8'hFF);
    // R7: upper-line aliases ignored
    for (int a = 0; a < 512; a += 5) wr_cyc(16'h0400 + 16'(a), 8'h00);
    wr_cyc(16'h8001, 8'hAA);

    // R1 R2 R3 R7: RAM readback
    for (int a = 0; a < 512; a++) rd_cyc(16'(a), 1'b1, "R1_R2_R3_R7 ram");
    // R4 R5 R6: ROM readback
    for (int a = 0; a < 512; a++) rd_cyc(16'h0200 + 16'(a), 1'b1, "R4_R5_R6 rom");
    // R7: upper lines set
    for (int k = 0; k < 6; k++) begin
      rd_cyc(16'(1 << (10 + k)), 1'b1, "R7 upper");
      rd_cyc(16'(1 << (10 + k)) | 16'h0205, 1'b1, "R5 rom_lo_select");
    end
    rd_cyc(16'hFFFF, 1'b1, "R7 upper all");
    // R8: read strobe low
    for (int a = 0; a < 1024; a += 37) rd_cyc(16'(a), 1'b0, "R8 no_read");
    // R2: overwrite and reread one byte per bank
    for (int b = 0; b < 4; b++) begin
      model[b*128 + 9] = 8'hC0 + 8'(b);
      wr_cyc(16'(b*128 + 9), 8'hC0 + 8'(b));
      rd_cyc(16'(b*128 + 9), 1'b1, "R2 overwrite");
    end
    // R10: write blocked in reset
    @(negedge clk) rst_n = 1'b0;
    wr_cyc(16'h0003, 8'h77);
    @(negedge clk) rst_n = 1'b1;
    rd_cyc(16'h0003, 1'b1, "R10 reset_write");

    @(negedge clk); @(negedge clk);
    rd = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule